// File: doc/BRIEF.md
# Interrupt Enable and Dispatch Controller

This block decides, once per instruction boundary, whether the processor core should leave its instruction stream and enter an interrupt handler. It keeps two bus-visible registers: a mask that enables each interrupt source and a latch that holds each source's outstanding request. Peripherals raise requests with single-cycle pulses. Software reads and writes both registers through a simple address/data port.

A three-state master switch gates the whole mechanism. The core reports its enable, disable and return-from-interrupt instructions through strobes, and the block steps the switch from those strobes. When the core signals a boundary, the switch is fully on and at least one source is both enabled and requested, the block picks the lowest-numbered such source. It clears that source's request and emits a one-cycle dispatch pulse carrying the handler address. The core then pushes its program counter and jumps; this block only announces that the core must do so.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After synchronous reset the enable mask and request latch are all zero and the master switch is off, so a boundary produces no dispatch even once sources are enabled and requested.
- R2: A bus write to 0xFFFF loads the enable mask from write data bits [4:0]. A write to 0xFF0F loads the request latch from bits [4:0]. Reading 0xFFFF returns the mask with bits [7:5] as 0, and reading 0xFF0F returns the latch with bits [7:5] as 1. Any other address reads 0x00, and a write to it changes neither register.
- R3: A request pulse on source i sets request bit i. When a bus write to 0xFF0F and request pulses occur in the same cycle, the latch takes the OR of the written value and the pulses.
- R4: The candidate set is the enable mask ANDed with the request latch, and the lowest-numbered candidate wins.
- R5: The handler address for source i is 0x0040 + 8*i, which gives 0x40, 0x48, 0x50, 0x58 and 0x60 for sources 0 to 4. The address output reads 0 when no dispatch is shown.
- R6: A dispatch appears as a single-cycle pulse in the cycle after the boundary strobe is sampled. It clears only the winning source's request bit.
- R7: An enable strobe moves the switch from off to armed. The next boundary turns it on without dispatching, and a dispatch can occur at the boundary after that. If an enable strobe and a boundary arrive in the same cycle, the enable wins and the switch stays armed.
- R8: A disable strobe and taking an interrupt both turn the switch off, so no later boundary dispatches until the switch is turned on again.
- R9: A return-from-interrupt strobe turns the switch on at once, so the very next boundary may dispatch.
- R10: When several events land in one cycle, they take effect in this order: taking an interrupt first, then disable, then return-from-interrupt, then enable. A request pulse on the winning source in the dispatch cycle leaves that source's bit set.
- R11: No dispatch happens without a boundary strobe, with an empty candidate set, or while the switch is not on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pulse | input | 5 | One-cycle request pulse per source |
| bus_addr | input | 16 | Register access address |
| bus_wr | input | 1 | Write enable for the register access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ei_strobe | input | 1 | Core executed an enable-interrupts instruction |
| di_strobe | input | 1 | Core executed a disable-interrupts instruction |
| reti_strobe | input | 1 | Core executed a return-from-interrupt instruction |
| boundary_strobe | input | 1 | Core is between an execute and the next fetch |
| dispatch | output | 1 | One-cycle pulse: enter a handler |
| dispatch_vec | output | 16 | Handler address shown with dispatch |

## Verification
The table-driven part sweeps mask and request combinations. It catches a priority encoder that picks the highest source, a handler address off by one stride, and a clear that wipes every request bit instead of only the winner's. The directed tests concentrate on the delayed enable. A design that turned the switch on directly would dispatch at the first boundary after the enable strobe, and one that let a boundary override a same-cycle enable would dispatch one boundary early. The directed tests also cover same-cycle collisions: a pulse that lands on the winning source as it is dispatched must survive, and a bus write to the request latch must not drop a simultaneous pulse. A final check confirms that nothing dispatches a second time after a take before the switch is re-enabled.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int unsigned NUM_SRC    = 5;
    localparam int unsigned ADDR_W     = 16;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned VEC_W      = 16;
    localparam int unsigned VEC_STRIDE = 8;

    localparam logic [ADDR_W-1:0] MASK_ADDR  = 16'hFFFF;
    localparam logic [ADDR_W-1:0] LATCH_ADDR = 16'hFF0F;
    localparam logic [VEC_W-1:0]  VEC_BASE   = 16'h0040;

    // master switch: off, armed by an enable instruction, on
    typedef enum logic [1:0] {
        IME_OFF   = 2'd0,
        IME_ARMED = 2'd1,
        IME_ON    = 2'd2
    } ime_t;

    function automatic logic [VEC_W-1:0] src_vector(input int unsigned idx);
        return VEC_BASE + VEC_W'(idx * VEC_STRIDE);
    endfunction

endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC,
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned DW   = DATA_W,
    parameter logic [AW-1:0] EN_ADDR = MASK_ADDR,
    parameter logic [AW-1:0] FL_ADDR = LATCH_ADDR
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [NSRC-1:0] hw_req,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] latch_q,
    output logic [DW-1:0]   rdata
);

    logic            hit_mask, hit_latch;
    logic [NSRC-1:0] latch_base, latch_d;

    assign hit_mask  = (bus_addr == EN_ADDR);
    assign hit_latch = (bus_addr == FL_ADDR);

    // clear of the granted source first, new pulses last so none is lost
    always_comb begin
        latch_base = (bus_wr && hit_latch) ? bus_wdata[NSRC-1:0] : latch_q;
        latch_d    = (latch_base & ~clr_mask) | hw_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
            if (bus_wr && hit_mask)
                mask_q <= bus_wdata[NSRC-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_mask) begin
            rdata[NSRC-1:0] = mask_q;
        end else if (hit_latch) begin
            rdata           = '1;
            rdata[NSRC-1:0] = latch_q;
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC,
    parameter int unsigned VW   = VEC_W
) (
    input  logic [NSRC-1:0] mask,
    input  logic [NSRC-1:0] latch,
    output logic            any,
    output logic [NSRC-1:0] grant,
    output logic [VW-1:0]   vec
);

    logic [NSRC-1:0] cand;
    logic [NSRC:0]   seen;

    assign cand    = mask & latch;
    assign seen[0] = 1'b0;

    // lowest index wins: a source is granted if no lower one is a candidate
    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign grant[i]  = cand[i] & ~seen[i];
        assign seen[i+1] = seen[i] | cand[i];
    end

    assign any = seen[NSRC];

    always_comb begin
        vec = '0;
        for (int unsigned i = 0; i < NSRC; i++)
            if (grant[i]) vec = vec | VW'(src_vector(i));
    end

endmodule

// File: rtl/irq_master_fsm.sv
module irq_master_fsm
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic di,
    input  logic reti,
    input  logic ei,
    input  logic boundary,
    output ime_t state,
    output logic on
);

    ime_t state_d;

    always_comb begin
        state_d = state;
        if (take)
            state_d = IME_OFF;
        else if (di)
            state_d = IME_OFF;
        else if (reti)
            state_d = IME_ON;
        else if (ei)
            state_d = (state == IME_ON) ? IME_ON : IME_ARMED;
        else if (boundary && state == IME_ARMED)
            state_d = IME_ON;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= IME_OFF;
        else     state <= state_d;
    end

    assign on = (state == IME_ON);

endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC,
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned VW   = VEC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req_pulse,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            ei_strobe,
    input  logic            di_strobe,
    input  logic            reti_strobe,
    input  logic            boundary_strobe,
    output logic            dispatch,
    output logic [VW-1:0]   dispatch_vec
);

    logic [NSRC-1:0] mask_q, latch_q, grant, clr_mask;
    logic            any, ime_on, take;
    logic [VW-1:0]   vec_sel;
    ime_t            ime_state;

    assign take     = boundary_strobe & ime_on & any;
    assign clr_mask = take ? grant : '0;

    irq_regs #(.NSRC(NSRC), .AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .hw_req   (req_pulse),
        .clr_mask (clr_mask),
        .mask_q   (mask_q),
        .latch_q  (latch_q),
        .rdata    (bus_rdata)
    );

    irq_arbiter #(.NSRC(NSRC), .VW(VW)) u_arb (
        .mask (mask_q),
        .latch(latch_q),
        .any  (any),
        .grant(grant),
        .vec  (vec_sel)
    );

    irq_master_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .di      (di_strobe),
        .reti    (reti_strobe),
        .ei      (ei_strobe),
        .boundary(boundary_strobe),
        .state   (ime_state),
        .on      (ime_on)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dispatch     <= 1'b0;
            dispatch_vec <= '0;
        end else begin
            dispatch     <= take;
            dispatch_vec <= take ? vec_sel : '0;
        end
    end

endmodule

// File: rtl/irq_dispatch_ctrl_chk.sv
module irq_dispatch_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC,
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned VW   = VEC_W
) (
    input logic          clk,
    input logic          rst,
    input logic          boundary_strobe,
    input logic          dispatch,
    input logic [VW-1:0] dispatch_vec,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_rdata,
    input ime_t          ime_state
);

    localparam logic [VW-1:0] VEC_END = VEC_BASE + VW'(NSRC * VEC_STRIDE);

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        dispatch |=> !dispatch);

    p_needs_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        dispatch |-> $past(boundary_strobe));

    p_vec_legal_r5: assert property (@(posedge clk) disable iff (rst)
        dispatch |-> (dispatch_vec >= VEC_BASE && dispatch_vec < VEC_END
                      && dispatch_vec[2:0] == 3'b000));

    p_take_disables_r8: assert property (@(posedge clk) disable iff (rst)
        dispatch |-> ime_state == IME_OFF);

    p_gated_by_master_r11: assert property (@(posedge clk) disable iff (rst)
        (boundary_strobe && ime_state != IME_ON) |=> !dispatch);

    p_latch_pad_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == LATCH_ADDR) |-> bus_rdata[DW-1:NSRC] == '1);

endmodule

bind irq_dispatch_ctrl irq_dispatch_ctrl_chk #(
    .NSRC(NSRC), .AW(AW), .DW(DW), .VW(VW)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .boundary_strobe(boundary_strobe),
    .dispatch       (dispatch),
    .dispatch_vec   (dispatch_vec),
    .bus_addr       (bus_addr),
    .bus_rdata      (bus_rdata),
    .ime_state      (ime_state)
);

// File: tb/irq_dispatch_ctrl_tb.sv
module irq_dispatch_ctrl_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NTBL = 6;

    // table: mask, latch, expect take, expect vector, latch left after
    localparam logic [4:0]  T_MASK  [NTBL] = '{5'h1F, 5'h1E, 5'h10, 5'h0C, 5'h1F, 5'h03};
    localparam logic [4:0]  T_LATCH [NTBL] = '{5'h1F, 5'h1F, 5'h1F, 5'h0A, 5'h04, 5'h1C};
    localparam logic        T_TAKE  [NTBL] = '{1'b1,  1'b1,  1'b1,  1'b1,  1'b1,  1'b0};
    localparam logic [15:0] T_VEC   [NTBL] = '{16'h40, 16'h48, 16'h60, 16'h58, 16'h50, 16'h00};
    localparam logic [4:0]  T_LEFT  [NTBL] = '{5'h1E, 5'h1D, 5'h0F, 5'h02, 5'h00, 5'h1C};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  req_pulse = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ei_strobe = 1'b0, di_strobe = 1'b0, reti_strobe = 1'b0;
    logic        boundary_strobe = 1'b0;
    logic        dispatch;
    logic [15:0] dispatch_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dispatch_ctrl u_dut (
        .clk(clk), .rst(rst), .req_pulse(req_pulse),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ei_strobe(ei_strobe), .di_strobe(di_strobe),
        .reti_strobe(reti_strobe), .boundary_strobe(boundary_strobe),
        .dispatch(dispatch), .dispatch_vec(dispatch_vec)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // drive a set of strobes for one cycle; returns dispatch state after the edge
    task automatic strobe(input logic ei, input logic di, input logic reti,
                          input logic bnd, input logic [4:0] pulse,
                          output logic disp, output logic [15:0] vec);
        @(negedge clk);
        ei_strobe = ei; di_strobe = di; reti_strobe = reti;
        boundary_strobe = bnd; req_pulse = pulse;
        @(negedge clk);
        ei_strobe = 1'b0; di_strobe = 1'b0; reti_strobe = 1'b0;
        boundary_strobe = 1'b0; req_pulse = '0;
        disp = dispatch; vec = dispatch_vec;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  rd;
        logic        d;
        logic [15:0] v;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(16'hFFFF, rd); chk("R1 mask after reset", 16'(rd), 16'h00);
        bus_read(16'hFF0F, rd); chk("R1 latch after reset", 16'(rd), 16'hE0);
        chk("R1 no dispatch after reset", 16'(dispatch), 16'h0);

        // R2 register map and padding
        bus_write(16'hFFFF, 8'hFF);
        bus_read(16'hFFFF, rd); chk("R2 mask pad zero", 16'(rd), 16'h1F);
        bus_write(16'hFF0F, 8'h01);
        bus_read(16'hFF0F, rd); chk("R2 latch pad ones", 16'(rd), 16'hE1);
        bus_write(16'hFF10, 8'h1F);
        bus_read(16'hFF10, rd); chk("R2 unmapped reads zero", 16'(rd), 16'h00);
        bus_read(16'hFF0F, rd); chk("R2 unmapped write ignored latch", 16'(rd), 16'hE1);
        bus_read(16'hFFFF, rd); chk("R2 unmapped write ignored mask", 16'(rd), 16'h1F);

        // R1/R11 switch off at reset: candidate present but no take
        strobe(0, 0, 0, 1, 5'h0, d, v); chk("R1 switch off blocks dispatch", 16'(d), 16'h0);

        // R7 enable together with boundary: stays armed
        strobe(1, 0, 0, 1, 5'h0, d, v); chk("R7 ei with boundary no take", 16'(d), 16'h0);
        strobe(0, 0, 0, 1, 5'h0, d, v); chk("R7 arming boundary no take", 16'(d), 16'h0);
        strobe(0, 0, 0, 1, 5'h0, d, v); chk("R7 take after delay", 16'(d), 16'h1);
        chk("R5 vector source0", v, 16'h0040);
        @(negedge clk);
        chk("R6 pulse one cycle", 16'(dispatch), 16'h0);
        bus_read(16'hFF0F, rd); chk("R6 granted bit cleared", 16'(rd), 16'hE0);

        // R11 no boundary, no dispatch
        bus_write(16'hFF0F, 8'h02);
        strobe(0, 0, 1, 0, 5'h0, d, v); chk("R11 no boundary no take", 16'(d), 16'h0);
        strobe(0, 1, 0, 0, 5'h0, d, v);

        // R8 after take the switch is off
        strobe(0, 0, 0, 1, 5'h0, d, v); chk("R8 di keeps off", 16'(d), 16'h0);
        strobe(0, 0, 1, 1, 5'h0, d, v); chk("R9 reti with boundary uses old off state", 16'(d), 16'h0);
        strobe(0, 0, 0, 1, 5'h0, d, v); chk("R9 reti enables at once", 16'(d), 16'h1);
        chk("R5 vector source1", v, 16'h0048);
        bus_write(16'hFF0F, 8'h02);
        strobe(0, 0, 0, 1, 5'h0, d, v); chk("R8 take disables", 16'(d), 16'h0);

        // R10 priorities among strobes
        strobe(1, 1, 0, 0, 5'h0, d, v);
        strobe(0, 0, 0, 1, 5'h0, d, v);
        strobe(0, 0, 0, 1, 5'h0, d, v); chk("R10 di beats ei", 16'(d), 16'h0);
        strobe(0, 1, 1, 0, 5'h0, d, v);
        strobe(0, 0, 0, 1, 5'h0, d, v); chk("R10 di beats reti", 16'(d), 16'h0);

        // R10 pulse on winner during take keeps the bit
        bus_write(16'hFF0F, 8'h01);
        strobe(0, 0, 1, 0, 5'h0, d, v);
        strobe(0, 0, 0, 1, 5'h01, d, v); chk("R10 take with pulse", 16'(d), 16'h1);
        bus_read(16'hFF0F, rd); chk("R10 winner bit kept", 16'(rd), 16'hE1);

        // R3 pulses and same-cycle write merge
        bus_write(16'hFF0F, 8'h00);
        strobe(0, 0, 0, 0, 5'h08, d, v);
        bus_read(16'hFF0F, rd); chk("R3 pulse sets bit", 16'(rd), 16'hE8);
        @(negedge clk);
        bus_addr = 16'hFF0F; bus_wdata = 8'h01; bus_wr = 1'b1; req_pulse = 5'h04;
        @(negedge clk);
        bus_wr = 1'b0; req_pulse = '0;
        bus_read(16'hFF0F, rd); chk("R3 write OR pulse", 16'(rd), 16'hE5);

        // R4 R5 R9 R11 table sweep
        for (int i = 0; i < NTBL; i++) begin
            strobe(0, 1, 0, 0, 5'h0, d, v);
            bus_write(16'hFFFF, {3'b000, T_MASK[i]});
            bus_write(16'hFF0F, {3'b000, T_LATCH[i]});
            strobe(0, 0, 1, 0, 5'h0, d, v);
            strobe(0, 0, 0, 1, 5'h0, d, v);
            chk($sformatf("R4 take row %0d", i), 16'(d), 16'(T_TAKE[i]));
            chk($sformatf("R5 vector row %0d", i), v, T_VEC[i]);
            bus_read(16'hFF0F, rd);
            chk($sformatf("R6 latch left row %0d", i), 16'(rd), 16'({3'b111, T_LEFT[i]}));
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule